// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that follows a chain of block descriptors stored in memory. Software places a chain of four-word descriptors in memory, writes the address of the first one into the channel's configuration register, sets the global enable, and then sets the channel enable. For each block the channel reads the descriptor over its master port and then copies the block one item at a time. Each item is a read from the source followed by a write to the destination. After that the channel follows the next-descriptor pointer.

A next pointer of zero marks the final block. When that block finishes, the channel pulses its chain-complete interrupt and clears its own channel-enable bit, so software can learn the outcome either from the interrupt or by polling. Every block, including an empty one, gives a one-cycle block-complete pulse. Software can cancel a running chain by writing 0 to the channel enable. The channel then finishes the item it is working on and goes quiet.

Top module: `dma_ll_channel`

## Requirements
- R1: While global enable (register index 0, bit 0) is 0, the master port raises no request, even when the channel enable is 1. Setting global enable lets the pending chain start.
- R2: Writing 1 to the channel enable (index 1, bit 0) starts the channel at the pointer held in index 2. A descriptor is fetched as four word reads (size code 2) at pointer+0, +4, +8 and +12. These words are the source address, the destination address, the next pointer and the control word.
- R3: Control word layout: bits 21:0 item count, 23:22 source size, 25:24 destination size, 27:26 source mode, 29:28 destination mode, bit 30 source-is-peripheral, bit 31 destination-is-peripheral. Size codes are 0 byte, 1 half, 2 word. Each item is one read at the source size, then one write at the destination size.
- R4: Address modes: 0 steps the address up by the size in bytes after each item, 1 steps it down by the same amount, and 2 or 3 keep it fixed.
- R5: A side flagged as peripheral keeps its address fixed, whatever its mode field says.
- R6: Data is right-justified on the bus. Read data is cut to the source size, and the write carries that value cut or zero-extended to the destination size.
- R7: When the block whose next pointer is 0 completes, the chain-complete interrupt pulses for one cycle. In the same cycle the channel enable reads back 0.
- R8: The block-complete interrupt pulses for exactly one cycle, in the cycle after the handshake that ends a block.
- R9: A block with an item count of 0 moves no data. Its block-complete pulse follows the handshake of the descriptor's last word.
- R10: Writing 0 to the channel enable during a chain lets the current item finish. After that the channel raises no further requests and gives no interrupt.
- R11: Once raised, a request holds its address, direction and size unchanged until it is acknowledged.
- R12: After reset all three registers read 0, and there is no request and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index (0 global enable, 1 channel enable, 2 first descriptor pointer) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx, combinational |
| m_req | output | 1 | Master request |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | 32 | Master byte address |
| m_size | output | 2 | Access size code: 0 byte, 1 half, 2 word |
| m_wdata | output | 32 | Right-justified write data |
| m_rdata | input | 32 | Right-justified read data, valid with m_ack |
| m_ack | input | 1 | Acknowledge; the transfer happens on a clock edge with m_req and m_ack both high |
| irq_block | output | 1 | One-cycle block-complete pulse |
| irq_done | output | 1 | One-cycle chain-complete pulse |

## Verification
A master transfer completes on the edge where both request and acknowledge are high. The bench therefore compares address, size, direction and write data at the falling edge where it raises the acknowledge, because those values are then final. The interrupt flags are registered on that same edge. Both pulses are therefore due one cycle after the ending handshake, and the bench checks them at the next falling edge against flags set by the reference model. Register reads are combinational, so the value is sampled one falling edge after the index is driven. A cancelled chain is judged at the handshake level: the write of the current item must still appear, and any later request is a failure.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;

    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int LEN_W = 22;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} xsize_e;
    typedef enum logic [1:0] {AM_INC = 2'd0, AM_DEC = 2'd1, AM_FIX = 2'd2, AM_FIX2 = 2'd3} amode_e;
    typedef enum logic [1:0] {ST_IDLE, ST_DESC, ST_RD, ST_WR} st_e;

    typedef struct packed {
        logic             dst_per;
        logic             src_per;
        amode_e           dst_mode;
        amode_e           src_mode;
        xsize_e           dst_sz;
        xsize_e           src_sz;
        logic [LEN_W-1:0] len;
    } ctl_t;

    function automatic logic [2:0] xbytes(xsize_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DW-1:0] fit(logic [DW-1:0] d, xsize_e sz);
        case (sz)
            SZ_BYTE: return {{(DW-8){1'b0}}, d[7:0]};
            SZ_HALF: return {{(DW-16){1'b0}}, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [AW-1:0] next_addr(logic [AW-1:0] a, xsize_e sz, amode_e md, logic per);
        logic [AW-1:0] stride;
        stride = AW'(xbytes(sz));
        if (per) return a;
        case (md)
            AM_INC:  return a + stride;
            AM_DEC:  return a - stride;
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/dma_ll_regs.sv
module dma_ll_regs
    import dma_ll_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_idx,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          hw_clr,
    output logic          gen_en,
    output logic          chan_en,
    output logic [AW-1:0] first_ptr
);

    localparam logic [1:0] IX_GEN = 2'd0;
    localparam logic [1:0] IX_CH  = 2'd1;
    localparam logic [1:0] IX_PTR = 2'd2;

    logic sw_ch_wr;
    assign sw_ch_wr = reg_we && (reg_idx == IX_CH);

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en    <= 1'b0;
            chan_en   <= 1'b0;
            first_ptr <= '0;
        end else begin
            if (reg_we && reg_idx == IX_GEN) gen_en <= reg_wdata[0];
            if (reg_we && reg_idx == IX_PTR) first_ptr <= reg_wdata;
            if (sw_ch_wr)      chan_en <= reg_wdata[0];
            else if (hw_clr)   chan_en <= 1'b0;
        end
    end

    always_comb begin
        case (reg_idx)
            IX_GEN:  reg_rdata = {{(DW-1){1'b0}}, gen_en};
            IX_CH:   reg_rdata = {{(DW-1){1'b0}}, chan_en};
            IX_PTR:  reg_rdata = first_ptr;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine
    import dma_ll_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          gen_en,
    input  logic          chan_en,
    input  logic [AW-1:0] first_ptr,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_size,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ack,
    output logic          hw_clr,
    output logic          irq_block,
    output logic          irq_done
);

    localparam int DESC_WORDS = 4;
    localparam int WI_W       = $clog2(DESC_WORDS);
    localparam logic [WI_W-1:0] WI_LAST = WI_W'(DESC_WORDS - 1);

    st_e              st;
    logic [WI_W-1:0]  widx;
    logic [AW-1:0]    dptr, src_a, dst_a, nxt_a;
    ctl_t             ctl;
    logic [LEN_W-1:0] cnt;
    logic [DW-1:0]    data;
    logic             held;

    logic ack, fin_desc, fin_item, blk_end;
    ctl_t new_ctl;

    assign m_req   = (st != ST_IDLE) && (gen_en || held);
    assign ack     = m_req && m_ack;
    assign new_ctl = ctl_t'(m_rdata);

    always_comb begin
        m_we   = 1'b0;
        m_addr = dptr + {{(AW-WI_W-2){1'b0}}, widx, 2'b00};
        m_size = SZ_WORD;
        case (st)
            ST_RD: begin m_addr = src_a; m_size = ctl.src_sz; end
            ST_WR: begin m_addr = dst_a; m_size = ctl.dst_sz; m_we = 1'b1; end
            default: ;
        endcase
    end

    assign m_wdata  = fit(data, ctl.dst_sz);
    assign fin_desc = (st == ST_DESC) && ack && chan_en && (widx == WI_LAST) && (new_ctl.len == '0);
    assign fin_item = (st == ST_WR) && ack && chan_en && (cnt == LEN_W'(1));
    assign blk_end  = fin_desc || fin_item;
    assign hw_clr   = blk_end && (nxt_a == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            widx      <= '0;
            dptr      <= '0;
            src_a     <= '0;
            dst_a     <= '0;
            nxt_a     <= '0;
            ctl       <= '0;
            cnt       <= '0;
            data      <= '0;
            held      <= 1'b0;
            irq_block <= 1'b0;
            irq_done  <= 1'b0;
        end else begin
            irq_block <= 1'b0;
            irq_done  <= 1'b0;
            held      <= m_req && !m_ack;
            case (st)
                ST_IDLE: if (chan_en && gen_en) begin
                    dptr <= first_ptr;
                    widx <= '0;
                    st   <= ST_DESC;
                end
                ST_DESC: if (ack) begin
                    case (widx)
                        2'd0:    src_a <= m_rdata;
                        2'd1:    dst_a <= m_rdata;
                        2'd2:    nxt_a <= m_rdata;
                        default: begin ctl <= new_ctl; cnt <= new_ctl.len; end
                    endcase
                    widx <= widx + 1'b1;
                    if (!chan_en)                             st <= ST_IDLE;
                    else if (widx == WI_LAST && !fin_desc)    st <= ST_RD;
                end
                ST_RD: if (ack) begin
                    data <= fit(m_rdata, ctl.src_sz);
                    st   <= ST_WR;
                end
                ST_WR: if (ack) begin
                    src_a <= next_addr(src_a, ctl.src_sz, ctl.src_mode, ctl.src_per);
                    dst_a <= next_addr(dst_a, ctl.dst_sz, ctl.dst_mode, ctl.dst_per);
                    cnt   <= cnt - 1'b1;
                    if (!chan_en)      st <= ST_IDLE;
                    else if (!fin_item) st <= ST_RD;
                end
                default: st <= ST_IDLE;
            endcase
            if (blk_end) begin
                irq_block <= 1'b1;
                if (nxt_a == '0) begin
                    irq_done <= 1'b1;
                    st       <= ST_IDLE;
                end else begin
                    dptr <= nxt_a;
                    widx <= '0;
                    st   <= ST_DESC;
                end
            end
        end
    end

endmodule

// File: rtl/dma_ll_channel.sv
module dma_ll_channel
    import dma_ll_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_idx,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          m_req,
    output logic          m_we,
    output logic [31:0]   m_addr,
    output logic [1:0]    m_size,
    output logic [31:0]   m_wdata,
    input  logic [31:0]   m_rdata,
    input  logic          m_ack,
    output logic          irq_block,
    output logic          irq_done
);

    logic          gen_en, chan_en, hw_clr;
    logic [AW-1:0] first_ptr;

    dma_ll_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_clr(hw_clr), .gen_en(gen_en), .chan_en(chan_en), .first_ptr(first_ptr)
    );

    dma_ll_engine u_eng (
        .clk(clk), .rst(rst),
        .gen_en(gen_en), .chan_en(chan_en), .first_ptr(first_ptr),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
        .hw_clr(hw_clr), .irq_block(irq_block), .irq_done(irq_done)
    );

endmodule

// File: rtl/dma_ll_chk.sv
module dma_ll_chk (
    input logic        clk,
    input logic        rst,
    input logic        gen_en,
    input logic        chan_en,
    input logic        m_req,
    input logic        m_ack,
    input logic        m_we,
    input logic [31:0] m_addr,
    input logic [1:0]  m_size,
    input logic        irq_block,
    input logic        irq_done
);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_size)));

    // R1
    gen_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(m_req) |-> gen_en);

    // R7
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> !chan_en);

    // R8
    done_with_block_chk: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> irq_block);

    // R8
    block_after_hs_chk: assert property (@(posedge clk) disable iff (rst)
        irq_block |-> $past(m_req && m_ack));

endmodule

bind dma_ll_channel dma_ll_chk u_chk (
    .clk(clk), .rst(rst), .gen_en(gen_en), .chan_en(chan_en),
    .m_req(m_req), .m_ack(m_ack), .m_we(m_we), .m_addr(m_addr), .m_size(m_size),
    .irq_block(irq_block), .irq_done(irq_done)
);

// File: tb/tb_dma_ll_channel.sv
`timescale 1ns/1ps
module tb_dma_ll_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic [1:0]  m_size;
    logic [31:0] m_rdata = '0;
    logic        m_ack = 1'b0;
    logic        irq_block, irq_done;

    always #4 clk = ~clk;

    dma_ll_channel dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
        .irq_block(irq_block), .irq_done(irq_done)
    );

    typedef struct {
        bit        we;
        bit [31:0] addr;
        bit [1:0]  size;
        bit [31:0] wdata;
        bit        blk;
        bit        done;
        string     tag;
    } txn_t;

    bit [7:0] mem [int];
    txn_t     exp_q[$];
    int nchk = 0, nfail = 0;
    int hs_cnt = 0, wait_cnt = 0, req_seen = 0, blk_seen = 0, done_seen = 0;
    int abort_at = 0;
    bit exp_blk = 0, exp_done = 0, finished = 0;
    bit pw_req = 0;
    bit [31:0] pw_addr = '0, last_rdata = '0;
    bit pend = 0, pend_we = 0;
    bit [1:0]  pend_idx = '0;
    bit [31:0] pend_data = '0;

    function automatic int nb(bit [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit [31:0] rdm(bit [31:0] a, int n);
        bit [31:0] v = '0;
        for (int i = 0; i < n; i++) if (mem.exists(int'(a + i))) v[8*i +: 8] = mem[int'(a + i)];
        return v;
    endfunction

    task automatic wrm(bit [31:0] a, bit [31:0] v, int n);
        for (int i = 0; i < n; i++) mem[int'(a + i)] = v[8*i +: 8];
    endtask

    function automatic bit [31:0] cut(bit [31:0] v, int n);
        return (n == 4) ? v : (v & ((32'd1 << (8*n)) - 1));
    endfunction

    function automatic bit [31:0] stepa(bit [31:0] a, int n, int md, bit per);
        if (per || md >= 2) return a;
        return (md == 0) ? a + n : a - n;
    endfunction

    function automatic bit [31:0] mkctl(int len, int ssz, int dsz, int smd, int dmd, bit sp, bit dp);
        return {dp, sp, 2'(dmd), 2'(smd), 2'(dsz), 2'(ssz), 22'(len)};
    endfunction

    task automatic put_desc(bit [31:0] p, bit [31:0] s, bit [31:0] d, bit [31:0] n, bit [31:0] c);
        wrm(p, s, 4); wrm(p + 4, d, 4); wrm(p + 8, n, 4); wrm(p + 12, c, 4);
    endtask

    task automatic fail(string req, string what, bit [31:0] act, bit [31:0] exp);
        nfail++;
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    task automatic check(string req, string what, bit [31:0] act, bit [31:0] exp);
        nchk++;
        if (act !== exp) fail(req, what, act, exp);
    endtask

    // Reference model: walks the chain in bench memory and lists every expected handshake
    task automatic build(bit [31:0] first);
        bit [31:0] p = first;
        for (int b = 0; b < 16; b++) begin
            bit [31:0] s = rdm(p, 4), d = rdm(p + 4, 4), n = rdm(p + 8, 4), c = rdm(p + 12, 4);
            int len = int'(c[21:0]);
            int sn = nb(c[23:22]), dn = nb(c[25:24]);
            txn_t t;
            for (int w = 0; w < 4; w++) begin
                t = '{we: 0, addr: p + 4*w, size: 2'd2, wdata: '0, blk: 0, done: 0, tag: "R2"};
                if (w == 3 && len == 0) begin t.blk = 1; t.done = (n == 0); end
                exp_q.push_back(t);
            end
            for (int i = 0; i < len; i++) begin
                t = '{we: 0, addr: s, size: c[23:22], wdata: '0, blk: 0, done: 0,
                      tag: c[30] ? "R5" : "R4"};
                exp_q.push_back(t);
                t = '{we: 1, addr: d, size: c[25:24], wdata: cut(cut(rdm(s, sn), sn), dn),
                      blk: (i == len - 1), done: (i == len - 1) && (n == 0), tag: c[31] ? "R5" : "R4"};
                exp_q.push_back(t);
                s = stepa(s, sn, int'(c[27:26]), c[30]);
                d = stepa(d, dn, int'(c[29:28]), c[31]);
            end
            if (n == 0) break;
            p = n;
        end
    endtask

    // One clock of memory responder, register driver and per-clock comparison
    task automatic cycle();
        txn_t t;
        @(negedge clk);
        last_rdata = reg_rdata;
        if (exp_blk || irq_block) check("R8", "irq_block", irq_block, exp_blk);
        if (exp_done || irq_done) check("R7", "irq_done", irq_done, exp_done);
        blk_seen  += int'(irq_block);
        done_seen += int'(irq_done);
        exp_blk = 0; exp_done = 0;
        if (pw_req) begin
            nchk++;
            if (!m_req || m_addr !== pw_addr) fail("R11", "request held", {m_req, m_addr[30:0]}, {1'b1, pw_addr[30:0]});
        end
        m_ack  = 1'b0;
        reg_we = 1'b0;
        if (pend) begin
            reg_idx = pend_idx; reg_wdata = pend_data; reg_we = pend_we; pend = 0;
        end
        if (m_req) begin
            req_seen++;
            if (wait_cnt < hs_cnt % 3) wait_cnt++;
            else begin
                wait_cnt = 0; hs_cnt++; m_ack = 1'b1;
                if (exp_q.size() == 0) begin
                    fail("R10", "unexpected request at", m_addr, 32'hffff_ffff);
                end else begin
                    t = exp_q.pop_front();
                    check(t.tag, "direction", m_we, t.we);
                    check("R3", "size", m_size, t.size);
                    check(t.tag, "address", m_addr, t.addr);
                    if (t.we) check("R6", "write data", m_wdata, t.wdata);
                    exp_blk = t.blk; exp_done = t.done;
                end
                if (m_we) wrm(m_addr, m_wdata, nb(m_size));
                else m_rdata = rdm(m_addr, nb(m_size));
                if (abort_at != 0 && hs_cnt == abort_at) begin
                    reg_idx = 2'd1; reg_wdata = '0; reg_we = 1'b1;
                end
            end
        end
        pw_req  = m_req && !m_ack;
        pw_addr = m_addr;
    endtask

    task automatic reg_write(bit [1:0] idx, bit [31:0] v);
        pend = 1; pend_we = 1; pend_idx = idx; pend_data = v;
        cycle();
    endtask

    task automatic reg_read(bit [1:0] idx, output bit [31:0] v);
        pend = 1; pend_we = 0; pend_idx = idx; pend_data = '0;
        cycle(); cycle();
        v = last_rdata;
    endtask

    task automatic wait_idle();
        bit [31:0] v;
        for (int k = 0; k < 400; k++) begin
            reg_read(2'd1, v);
            if (v[0] == 1'b0) break;
            repeat (6) cycle();
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", nfail + 1, nchk + 1);
            $finish;
        end
    end

    initial begin
        bit [31:0] v;
        int b0, d0, base;
        for (int i = 0; i < 64; i++) begin
            mem[32'h1000 + i] = 8'(i * 7 + 3);
            mem[32'h1100 + i] = 8'(i * 13 + 200);
            mem[32'h1200 + i] = 8'(i * 5 + 17);
        end
        // chain A: word copy, byte dec -> fixed half, empty block, peripheral word -> byte dec
        put_desc(32'h100, 32'h1000, 32'h2000, 32'h140, mkctl(4, 2, 2, 0, 0, 0, 0));
        put_desc(32'h140, 32'h1107, 32'h2100, 32'h180, mkctl(3, 0, 1, 1, 2, 0, 0));
        put_desc(32'h180, 32'h0,    32'h0,    32'h1c0, mkctl(0, 2, 2, 0, 0, 0, 0));
        put_desc(32'h1c0, 32'h1010, 32'h2203, 32'h0,   mkctl(3, 2, 0, 0, 1, 1, 0));
        put_desc(32'h300, 32'h1200, 32'h2300, 32'h0,   mkctl(5, 2, 2, 0, 0, 0, 0));

        repeat (4) cycle();
        rst = 1'b0;
        cycle();
        // R12 reset state
        check("R12", "m_req after reset", m_req, 0);
        check("R12", "irqs after reset", {irq_block, irq_done}, 0);
        reg_read(2'd0, v); check("R12", "global enable reset", v, 0);
        reg_read(2'd1, v); check("R12", "channel enable reset", v, 0);
        reg_read(2'd2, v); check("R12", "pointer reset", v, 0);

        // R1 gating by global enable
        build(32'h100);
        reg_write(2'd2, 32'h100);
        reg_write(2'd1, 32'h1);
        repeat (20) cycle();
        check("R1", "requests while global enable off", req_seen, 0);
        reg_read(2'd1, v); check("R2", "channel enable set", v, 1);
        b0 = blk_seen; d0 = done_seen;
        reg_write(2'd0, 32'h1);
        wait_idle();
        repeat (4) cycle();
        check("R2", "chain A handshakes left", exp_q.size(), 0);
        check("R9", "block pulses incl. empty block", blk_seen - b0, 4);
        check("R7", "chain-complete pulses", done_seen - d0, 1);
        reg_read(2'd1, v); check("R7", "channel enable cleared", v, 0);
        check("R5", "fixed half destination final", rdm(32'h2100, 2), {24'h0, mem[32'h1105]});
        check("R4", "decrement byte destination low end", rdm(32'h2201, 1), {24'h0, mem[32'h1010]});

        // R10 cancel after the second item's read
        build(32'h300);
        while (exp_q.size() > 8) void'(exp_q.pop_back());
        base = hs_cnt;
        abort_at = base + 7;
        b0 = blk_seen; d0 = done_seen;
        reg_write(2'd2, 32'h300);
        reg_write(2'd1, 32'h1);
        repeat (60) cycle();
        check("R10", "handshakes left after cancel", exp_q.size(), 0);
        check("R10", "handshakes after cancel", hs_cnt - base, 8);
        check("R10", "no interrupts after cancel", (blk_seen - b0) + (done_seen - d0), 0);
        check("R10", "request idle", m_req, 0);
        reg_read(2'd1, v); check("R10", "channel enable reads 0", v, 0);
        check("R6", "second item written", rdm(32'h2304, 4), rdm(32'h1204, 4));
        check("R10", "third item not written", rdm(32'h2308, 4), 0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", nfail, nchk);
        $finish;
    end

endmodule